// File: doc/BRIEF.md
# Parallel ADC Capture Sequencer

This block sits on the host side of a 12-bit sampling converter that has a parallel output bus. It drives the converter's chip-select, read, conversion-start and power-down lines, and it watches the converter's busy line. Everything runs in system-clock cycles. A conversion is triggered by a single-cycle request or by a built-in sample-rate divider. The start strobe is held low for a minimum width. The controller then waits for busy to return high and collects the result word in one of three handshake styles. The result is delivered as a one-cycle valid pulse with the word zero- or sign-extended to the output width.

The controller enforces the converter's timing rules. The start line is never changed while a conversion is under way. A new start is held back until an acquisition interval has passed since the previous result. After power-down is released, no start is issued until a wake-up delay has elapsed. A request that cannot be served is reported as an overrun rather than queued. A converter that never reports completion is abandoned after a timeout.

Top module: `adc_capture_ctrl`

## Requirements
- R1: After reset, conv_n_o and shdn_n_o are 1, cs_n_o is 0, rd_n_o is 0 (mode 0 selected), and smp_valid_o, overrun_o and timeout_o are 0.
- R2: With mode_sel = 0 (and also with the unused value 3), cs_n_o and rd_n_o stay low while awake. The word on adc_data_i is captured one cycle after busy_n_i is first seen high again, and it appears on smp_data_o with a one-cycle smp_valid_o.
- R3: With mode_sel = 1, rd_n_o falls only after busy has returned high. It stays low for READ_LOW cycles, and the bus is sampled after rd_n_o has been low for ACCESS_WAIT cycles.
- R4: With mode_sel = 2, rd_n_o follows conv_n_o. Each strobe delivers the result of the previous conversion, sampled after ACCESS_WAIT cycles of strobe. The first strobe after reset or wake-up delivers nothing.
- R5: conv_n_o stays low for START_LOW cycles. It falls only while busy_n_i is high, and once it is high during a conversion it does not change until busy returns high.
- R6: When fmt_signed is 1, the 12-bit word is sign-extended into smp_data_o (two's complement). When it is 0, the word is zero-extended.
- R7: With rate_en = 1, a trigger is generated every rate_div + 1 cycles.
- R8: A trigger that arrives while a conversion or read is in progress, or while one trigger is already pending, pulses overrun_o for one cycle and is dropped.
- R9: If busy does not return high within TIMEOUT_CYC cycles of the start strobe ending, timeout_o pulses once, no word is delivered, and the controller accepts the next trigger.
- R10: While sleep_req is 1 and the controller is idle, shdn_n_o and cs_n_o are driven inactive (0 and 1), and triggers are ignored without an overrun. After release, conv_n_o does not fall until at least WAKE_CYC cycles after shdn_n_o rises.
- R11: conv_n_o does not fall within ACQ_CYC cycles after busy returns high. A trigger that arrives in that interval is held and served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Handshake style: 0 latch on busy, 1 separate read, 2 start tied to read |
| fmt_signed | input | 1 | 1: sign-extend result, 0: zero-extend |
| req_i | input | 1 | Single-cycle conversion request |
| rate_en | input | 1 | Enable periodic triggers |
| rate_div | input | CNT_W | Trigger period minus one, in cycles |
| sleep_req | input | 1 | Request converter power-down |
| busy_n_i | input | 1 | Converter busy, low during conversion |
| adc_data_i | input | DATA_W | Converter parallel data bus |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read enable, active low |
| conv_n_o | output | 1 | Conversion start strobe, active low |
| shdn_n_o | output | 1 | Power-down control, low = powered down |
| smp_valid_o | output | 1 | One-cycle result valid |
| smp_data_o | output | OUT_W | Extended result word |
| overrun_o | output | 1 | Dropped trigger pulse |
| timeout_o | output | 1 | Missing busy completion pulse |

## Verification
The converter model drives garbage on the bus until read has been low for two cycles. A controller that samples too early in separate-read or tied mode therefore returns the wrong word. In tied mode the bench checks that the first strobe after wake-up returns nothing and that each later strobe returns the word from one conversion earlier; an off-by-one in the result pipeline would return the current or a stale word. The model measures the gap from power-up to the first start, the gap from busy rising to the next start, the start and read low widths, and any start edge during the bit-decision window, so a shortened guard or an early release would show up as a violation. Two further cases are exercised: a dead converter, where a missing timeout would hang the controller, and closely spaced triggers, where they must be counted as overruns rather than silently converted twice.

// File: rtl/adc_cap_pkg.sv
// Shared types for the parallel ADC capture sequencer.
package adc_cap_pkg;
    // Handshake style; the unused code 3 behaves as MODE_LATCH.
    typedef enum logic [1:0] {
        MODE_LATCH = 2'd0,
        MODE_SEPRD = 2'd1,
        MODE_TIED  = 2'd2
    } cap_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLEEP,
        ST_START,
        ST_WAIT,
        ST_READ
    } seq_state_e;
endpackage

// File: rtl/adc_cap_tick.sv
// Periodic trigger generator.
// Emits a one-cycle tick every div_i+1 cycles while en_i is high.
// Assumes div_i is held stable while enabled; clearing en_i restarts the period.
module adc_cap_tick #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] div_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count cycles and fire the tick on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == div_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0 && en_i) |=> !tick_o); // R7
endmodule

// File: rtl/adc_cap_hold.sv
// Hold-off timer: after a load pulse, active_o stays high for LEN cycles.
// Used for the wake-up delay and for the acquisition interval.
// Assumes LEN >= 1.
module adc_cap_hold #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic active_o
);
    localparam int W = $clog2(LEN + 1);

    logic [W-1:0] cnt_q;

    // Reload on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= W'(LEN);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);

    AST_HOLD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> active_o); // R11
endmodule

// File: rtl/adc_cap_fmt.sv
// Result formatter: widens the captured word to OUT_W bits, either as
// two's complement (sign extension) or unsigned (zero extension), and
// registers it with a one-cycle valid. Assumes OUT_W >= DATA_W.
module adc_cap_fmt #(
    parameter int DATA_W = 12,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              signed_i,
    output logic              valid_o,
    output logic [OUT_W-1:0]  data_o
);
    localparam int EXT_W = OUT_W - DATA_W;

    logic [OUT_W-1:0] wide;

    generate
        if (EXT_W > 0) begin : g_ext
            // Choose the fill bits from the sign flag.
            always_comb begin
                wide = {{EXT_W{signed_i & word_i[DATA_W-1]}}, word_i};
            end
        end else begin : g_same
            always_comb begin
                wide = word_i;
            end
        end
    endgenerate

    // Register the widened word and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= stb_i;
            if (stb_i)
                data_o <= wide;
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R2
endmodule

// File: rtl/adc_cap_seq.sv
// Handshake sequencer for the converter.
// Issues the start strobe, tracks busy, collects the result in the chosen
// handshake style, manages power-down, and flags overruns and timeouts.
// Assumes busy_n_i and data_i are already synchronous to clk, and that
// ACCESS_WAIT <= START_LOW and ACCESS_WAIT <= READ_LOW, all >= 1.
module adc_cap_seq
    import adc_cap_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int CNT_W       = 16,
    parameter int START_LOW   = 4,
    parameter int READ_LOW    = 4,
    parameter int ACCESS_WAIT = 3,
    parameter int TIMEOUT_CYC = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              trig_i,
    input  logic              sleep_req_i,
    input  logic              busy_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              wake_busy_i,
    input  logic              acq_busy_i,
    output logic              start_n_o,
    output logic              rd_n_o,
    output logic              shdn_n_o,
    output cap_mode_e         mode_o,
    output logic              cap_stb_o,
    output logic [DATA_W-1:0] cap_word_o,
    output logic              overrun_o,
    output logic              timeout_o,
    output logic              wake_load_o,
    output logic              acq_load_o
);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_LOW - 1);
    localparam logic [CNT_W-1:0] READ_LAST  = CNT_W'(READ_LOW - 1);
    localparam logic [CNT_W-1:0] ACC_LAST   = CNT_W'(ACCESS_WAIT - 1);
    localparam logic [CNT_W-1:0] TO_LAST    = CNT_W'(TIMEOUT_CYC - 1);

    seq_state_e       state_q;
    cap_mode_e        mode_q;
    cap_mode_e        mode_in;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             pending_q;
    logic             have_prev_q;
    logic             busy_rise;
    logic             can_start;

    // Decode the requested style and the start-permission conditions.
    always_comb begin
        mode_in   = cap_mode_e'(mode_i);
        busy_rise = busy_n_i && !busy_q;
        can_start = !wake_busy_i && !acq_busy_i && busy_n_i;
    end

    assign wake_load_o = (state_q == ST_SLEEP) && !sleep_req_i;
    assign acq_load_o  = (state_q == ST_WAIT) && busy_rise;
    assign mode_o      = mode_q;

    // Main handshake state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mode_q      <= MODE_LATCH;
            cnt_q       <= '0;
            busy_q      <= 1'b1;
            pending_q   <= 1'b0;
            have_prev_q <= 1'b0;
            start_n_o   <= 1'b1;
            rd_n_o      <= 1'b1;
            shdn_n_o    <= 1'b1;
            cap_stb_o   <= 1'b0;
            cap_word_o  <= '0;
            overrun_o   <= 1'b0;
            timeout_o   <= 1'b0;
        end else begin
            busy_q    <= busy_n_i;
            cap_stb_o <= 1'b0;
            overrun_o <= 1'b0;
            timeout_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    mode_q <= mode_in;
                    if (sleep_req_i && !pending_q && !trig_i) begin
                        state_q  <= ST_SLEEP;
                        shdn_n_o <= 1'b0;
                    end else if ((pending_q || trig_i) && can_start) begin
                        state_q   <= ST_START;
                        start_n_o <= 1'b0;
                        cnt_q     <= '0;
                        pending_q <= 1'b0;
                        overrun_o <= pending_q && trig_i;
                        if (mode_in == MODE_TIED)
                            rd_n_o <= 1'b0;
                    end else if (trig_i) begin
                        if (pending_q)
                            overrun_o <= 1'b1;
                        else
                            pending_q <= 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (!sleep_req_i) begin
                        state_q     <= ST_IDLE;
                        shdn_n_o    <= 1'b1;
                        have_prev_q <= 1'b0;
                    end
                end
                ST_START: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (trig_i)
                        overrun_o <= 1'b1;
                    if (mode_q == MODE_TIED && cnt_q == ACC_LAST && have_prev_q) begin
                        cap_stb_o  <= 1'b1;
                        cap_word_o <= data_i;
                    end
                    if (cnt_q == START_LAST) begin
                        start_n_o <= 1'b1;
                        rd_n_o    <= 1'b1;
                        cnt_q     <= '0;
                        state_q   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (trig_i)
                        overrun_o <= 1'b1;
                    if (busy_rise) begin
                        have_prev_q <= 1'b1;
                        cnt_q       <= '0;
                        if (mode_q == MODE_SEPRD) begin
                            rd_n_o  <= 1'b0;
                            state_q <= ST_READ;
                        end else begin
                            state_q <= ST_IDLE;
                            if (mode_q != MODE_TIED) begin
                                cap_stb_o  <= 1'b1;
                                cap_word_o <= data_i;
                            end
                        end
                    end else if (cnt_q == TO_LAST) begin
                        timeout_o <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_READ: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (trig_i)
                        overrun_o <= 1'b1;
                    if (cnt_q == ACC_LAST) begin
                        cap_stb_o  <= 1'b1;
                        cap_word_o <= data_i;
                    end
                    if (cnt_q == READ_LAST) begin
                        rd_n_o  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_START_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_n_o) |-> $past(busy_n_i)); // R5
    AST_START_NO_MIDCONV: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n_i && start_n_o) |=> start_n_o); // R5
    AST_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n_o) && mode_q == MODE_SEPRD) |-> $past(busy_n_i)); // R3
    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |-> $past(trig_i)); // R8
    AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (state_q == ST_IDLE && start_n_o && !cap_stb_o)); // R9
endmodule

// File: rtl/adc_capture_ctrl.sv
// Top of the parallel ADC capture sequencer.
// Combines the trigger sources, the wake-up and acquisition hold-off timers,
// the handshake sequencer and the result formatter, and derives chip select
// and read from the sequencer state and the handshake style.
// Assumes START_LOW cycles of clk fit inside the converter's early window.
module adc_capture_ctrl
    import adc_cap_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int OUT_W       = 16,
    parameter int CNT_W       = 16,
    parameter int START_LOW   = 4,
    parameter int READ_LOW    = 4,
    parameter int ACCESS_WAIT = 3,
    parameter int WAKE_CYC    = 35,
    parameter int ACQ_CYC     = 16,
    parameter int TIMEOUT_CYC = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              fmt_signed,
    input  logic              req_i,
    input  logic              rate_en,
    input  logic [CNT_W-1:0]  rate_div,
    input  logic              sleep_req,
    input  logic              busy_n_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              cs_n_o,
    output logic              rd_n_o,
    output logic              conv_n_o,
    output logic              shdn_n_o,
    output logic              smp_valid_o,
    output logic [OUT_W-1:0]  smp_data_o,
    output logic              overrun_o,
    output logic              timeout_o
);
    logic              tick;
    logic              trig;
    logic              wake_active;
    logic              acq_active;
    logic              wake_load;
    logic              acq_load;
    logic              rd_pulse_n;
    cap_mode_e         mode_q;
    logic              cap_stb;
    logic [DATA_W-1:0] cap_word;

    adc_cap_tick #(.CNT_W(CNT_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en_i(rate_en), .div_i(rate_div), .tick_o(tick)
    );

    adc_cap_hold #(.LEN(WAKE_CYC)) u_wake (
        .clk(clk), .rst_n(rst_n), .load_i(wake_load), .active_o(wake_active)
    );

    adc_cap_hold #(.LEN(ACQ_CYC)) u_acq (
        .clk(clk), .rst_n(rst_n), .load_i(acq_load), .active_o(acq_active)
    );

    // Merge the explicit request with the periodic tick.
    assign trig = req_i | tick;

    adc_cap_seq #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .START_LOW(START_LOW),
        .READ_LOW(READ_LOW), .ACCESS_WAIT(ACCESS_WAIT), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_sel), .trig_i(trig),
        .sleep_req_i(sleep_req), .busy_n_i(busy_n_i), .data_i(adc_data_i),
        .wake_busy_i(wake_active), .acq_busy_i(acq_active),
        .start_n_o(conv_n_o), .rd_n_o(rd_pulse_n), .shdn_n_o(shdn_n_o),
        .mode_o(mode_q), .cap_stb_o(cap_stb), .cap_word_o(cap_word),
        .overrun_o(overrun_o), .timeout_o(timeout_o),
        .wake_load_o(wake_load), .acq_load_o(acq_load)
    );

    // Chip select follows power state; read is strobed or held low by style.
    always_comb begin
        cs_n_o = !shdn_n_o;
        if (!shdn_n_o)
            rd_n_o = 1'b1;
        else if (mode_q == MODE_SEPRD || mode_q == MODE_TIED)
            rd_n_o = rd_pulse_n;
        else
            rd_n_o = 1'b0;
    end

    adc_cap_fmt #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_fmt (
        .clk(clk), .rst_n(rst_n), .stb_i(cap_stb), .word_i(cap_word),
        .signed_i(fmt_signed), .valid_o(smp_valid_o), .data_o(smp_data_o)
    );

    AST_ASLEEP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n_o |-> conv_n_o); // R10
    AST_WAKE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        wake_active |-> conv_n_o); // R10
    AST_ACQ_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_n_o) |-> !$past(acq_active)); // R11
    AST_TIED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TIED && shdn_n_o) |-> (rd_n_o == conv_n_o)); // R4
endmodule

// File: tb/adc_capture_ctrl_tb_top.sv
// Directed bench with a behavioural converter model.
module adc_capture_ctrl_tb_top;
    localparam int START_LOW = 4;
    localparam int READ_LOW  = 4;
    localparam int WAKE_CYC  = 35;
    localparam int ACQ_CYC   = 16;
    localparam int CONV      = 20;
    localparam int EARLY     = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        fmt_signed = 1'b0;
    logic        req_i = 1'b0;
    logic        rate_en = 1'b0;
    logic [15:0] rate_div = 16'd0;
    logic        sleep_req = 1'b0;
    logic        busy_n;
    logic [11:0] bus;
    logic        cs_n_o, rd_n_o, conv_n_o, shdn_n_o, smp_valid_o, overrun_o, timeout_o;
    logic [15:0] smp_data_o;

    always #5 clk = ~clk;

    adc_capture_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .fmt_signed(fmt_signed),
        .req_i(req_i), .rate_en(rate_en), .rate_div(rate_div), .sleep_req(sleep_req),
        .busy_n_i(busy_n), .adc_data_i(bus), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o),
        .conv_n_o(conv_n_o), .shdn_n_o(shdn_n_o), .smp_valid_o(smp_valid_o),
        .smp_data_o(smp_data_o), .overrun_o(overrun_o), .timeout_o(timeout_o)
    );

    // ---------------- converter model and monitors ----------------
    logic        m_busy_n = 1'b1;
    logic [11:0] m_latch = 12'h000;
    logic [11:0] m_next = 12'h000;
    logic        m_en = 1'b1;
    int          m_t = 0;
    int          rd_lo = 0;
    logic        st_p = 1'b1, sh_p = 1'b1, rd_p = 1'b1, bz_p = 1'b1;
    int          cyc = 0, fall_at = 0, rdf_at = 0, rise_busy_at = -1000, wake_at = -1000;
    int          n_starts = 0, n_ovr = 0, n_to = 0;
    int          v_mid = 0, v_sleep = 0;
    int          min_sw = 1000, min_rw = 1000, min_acq = 1000, min_wake = 1000;

    assign busy_n = m_busy_n;
    assign bus    = (rd_lo >= 2) ? m_latch : 12'h5A5;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (overrun_o) n_ovr = n_ovr + 1;
            if (timeout_o) n_to = n_to + 1;
            if (st_p != conv_n_o && m_t > EARLY) v_mid = v_mid + 1;
            if (st_p && !conv_n_o) begin
                n_starts = n_starts + 1;
                fall_at  = cyc - 1;
                if (!shdn_n_o || cs_n_o) v_sleep = v_sleep + 1;
                if (fall_at - rise_busy_at < min_acq) min_acq = fall_at - rise_busy_at;
                if (fall_at - wake_at < min_wake) min_wake = fall_at - wake_at;
                if (m_en && m_t == 0) m_t <= 1;
            end
            if (!st_p && conv_n_o && (cyc - 1 - fall_at) < min_sw) min_sw = cyc - 1 - fall_at;
            if (rd_p && !rd_n_o) rdf_at = cyc - 1;
            if (!rd_p && rd_n_o && (cyc - 1 - rdf_at) < min_rw) min_rw = cyc - 1 - rdf_at;
            if (!sh_p && shdn_n_o) wake_at = cyc - 1;
            if (!bz_p && m_busy_n) rise_busy_at = cyc - 1;
        end
        st_p <= conv_n_o;
        rd_p <= rd_n_o;
        sh_p <= shdn_n_o;
        bz_p <= m_busy_n;
        rd_lo <= (!rd_n_o && !cs_n_o) ? ((rd_lo < 8) ? rd_lo + 1 : rd_lo) : 0;
        if (m_t != 0) begin
            m_t <= m_t + 1;
            if (m_t == 1) m_busy_n <= 1'b0;
            if (m_t == 1 + CONV) begin
                m_busy_n <= 1'b1;
                m_latch  <= m_next;
                m_t      <= 0;
            end
        end
    end

    // ---------------- bench bookkeeping ----------------
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_req();
        @(negedge clk) req_i = 1'b1;
        @(negedge clk) req_i = 1'b0;
    endtask

    task automatic wait_valid(input int lim, output bit got, output logic [15:0] d);
        got = 1'b0;
        d = '0;
        for (int i = 0; i < lim && !got; i++) begin
            @(negedge clk);
            if (smp_valid_o) begin got = 1'b1; d = smp_data_o; end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(conv_n_o && shdn_n_o && !cs_n_o && !rd_n_o, "R1 control lines", {conv_n_o, shdn_n_o, cs_n_o, rd_n_o}, 4'b1100);
        chk(!smp_valid_o && !overrun_o && !timeout_o, "R1 flags", {smp_valid_o, overrun_o, timeout_o}, 0);
    endtask

    task automatic t_latch(input logic [1:0] md, input logic [11:0] v);
        bit got; logic [15:0] d;
        mode_sel = md; fmt_signed = 1'b0; m_next = v;
        idle(2);
        pulse_req();
        chk(!rd_n_o && !cs_n_o, "R2 rd/cs held low", {rd_n_o, cs_n_o}, 0);
        wait_valid(100, got, d);
        chk(got && d == {4'h0, v}, "R2 latched word", d, {4'h0, v});
        idle(30);
    endtask

    task automatic t_sepread(input logic [11:0] v);
        bit got; logic [15:0] d;
        mode_sel = 2'd1; fmt_signed = 1'b0; m_next = v;
        idle(2);
        chk(rd_n_o, "R3 rd idle high", rd_n_o, 1);
        pulse_req();
        wait_valid(100, got, d);
        chk(got && d == {4'h0, v}, "R3 read-strobe word", d, {4'h0, v});
        chk(min_rw >= READ_LOW, "R3 read low width", min_rw, READ_LOW);
        idle(30);
    endtask

    task automatic t_signed();
        bit got; logic [15:0] d;
        mode_sel = 2'd0;
        fmt_signed = 1'b1; m_next = 12'h800; idle(2); pulse_req();
        wait_valid(100, got, d);
        chk(got && d == 16'hF800, "R6 negative sign-extended", d, 16'hF800);
        idle(30);
        m_next = 12'h7FF; pulse_req();
        wait_valid(100, got, d);
        chk(got && d == 16'h07FF, "R6 positive sign-extended", d, 16'h07FF);
        idle(30);
        fmt_signed = 1'b0; m_next = 12'hFFF; pulse_req();
        wait_valid(100, got, d);
        chk(got && d == 16'h0FFF, "R6 zero-extended", d, 16'h0FFF);
        idle(30);
    endtask

    task automatic t_back2back();
        bit got; logic [15:0] d;
        int s0, o0;
        mode_sel = 2'd0; m_next = 12'h123;
        pulse_req();
        wait_valid(100, got, d);
        s0 = n_starts; o0 = n_ovr;
        m_next = 12'h456;
        pulse_req();
        wait_valid(100, got, d);
        chk(got && d == 16'h0456, "R11 held trigger served", d, 16'h0456);
        chk(n_starts == s0 + 1 && n_ovr == o0, "R11 no overrun for held trigger", n_ovr - o0, 0);
        chk(min_acq >= ACQ_CYC, "R11 acquisition gap", min_acq, ACQ_CYC);
        idle(30);
    endtask

    task automatic t_overrun();
        bit got; logic [15:0] d;
        int s0, o0;
        mode_sel = 2'd0; m_next = 12'h2B7;
        s0 = n_starts; o0 = n_ovr;
        pulse_req();
        idle(8);
        pulse_req();
        wait_valid(100, got, d);
        idle(40);
        chk(n_ovr == o0 + 1, "R8 overrun pulses", n_ovr - o0, 1);
        chk(n_starts == s0 + 1, "R8 dropped trigger not converted", n_starts - s0, 1);
        chk(got && d == 16'h02B7, "R8 word intact", d, 16'h02B7);
    endtask

    task automatic t_rate();
        int s0, o0;
        mode_sel = 2'd0; m_next = 12'h0F0;
        s0 = n_starts; o0 = n_ovr;
        @(negedge clk) begin rate_div = 16'd59; rate_en = 1'b1; end
        idle(600);
        rate_en = 1'b0;
        idle(80);
        chk(n_starts - s0 >= 9 && n_starts - s0 <= 10, "R7 periodic start count", n_starts - s0, 10);
        chk(n_ovr == o0, "R7 no overrun at slow rate", n_ovr - o0, 0);
        o0 = n_ovr;
        @(negedge clk) begin rate_div = 16'd9; rate_en = 1'b1; end
        idle(200);
        rate_en = 1'b0;
        idle(80);
        chk(n_ovr > o0, "R8 overrun at fast rate", n_ovr - o0, 1);
    endtask

    task automatic t_timeout();
        bit got; logic [15:0] d;
        int t0;
        mode_sel = 2'd0; m_en = 1'b0; t0 = n_to;
        pulse_req();
        wait_valid(600, got, d);
        chk(!got, "R9 no word without completion", got, 0);
        chk(n_to == t0 + 1, "R9 timeout pulse", n_to - t0, 1);
        chk(conv_n_o, "R9 start released", conv_n_o, 1);
        m_en = 1'b1; m_next = 12'h3E8;
        idle(5);
        pulse_req();
        wait_valid(100, got, d);
        chk(got && d == 16'h03E8, "R9 recovers after timeout", d, 16'h03E8);
        idle(30);
    endtask

    task automatic t_sleep();
        bit got; logic [15:0] d;
        int s0, o0;
        mode_sel = 2'd0;
        sleep_req = 1'b1;
        idle(5);
        chk(!shdn_n_o && cs_n_o, "R10 powered down", {shdn_n_o, cs_n_o}, 2'b01);
        s0 = n_starts; o0 = n_ovr;
        pulse_req(); idle(5); pulse_req(); idle(5);
        chk(n_starts == s0 && n_ovr == o0 && conv_n_o, "R10 triggers ignored asleep", n_starts - s0, 0);
        m_next = 12'h64C;
        @(negedge clk) sleep_req = 1'b0;
        pulse_req();
        wait_valid(150, got, d);
        chk(got && d == 16'h064C, "R10 conversion after wake", d, 16'h064C);
        chk(min_wake >= WAKE_CYC, "R10 wake-up delay", min_wake, WAKE_CYC);
        idle(30);
    endtask

    task automatic t_tied();
        bit got; logic [15:0] d;
        int tie_bad = 0;
        mode_sel = 2'd2;
        sleep_req = 1'b1; idle(5);
        sleep_req = 1'b0; idle(50);
        m_next = 12'h111;
        pulse_req();
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (!conv_n_o && rd_n_o) tie_bad++;
            if (smp_valid_o) got = 1'b1;
        end
        chk(!got, "R4 first strobe after wake empty", got, 0);
        m_next = 12'h222;
        pulse_req();
        wait_valid(80, got, d);
        chk(got && d == 16'h0111, "R4 previous result on strobe", d, 16'h0111);
        idle(60);
        m_next = 12'h333;
        pulse_req();
        wait_valid(80, got, d);
        chk(got && d == 16'h0222, "R4 pipeline by one", d, 16'h0222);
        chk(tie_bad == 0, "R4 read follows start", tie_bad, 0);
        idle(60);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch(2'd0, 12'h3C5);
        t_latch(2'd3, 12'hA5A);
        t_sepread(12'h9E1);
        t_signed();
        t_back2back();
        t_overrun();
        t_rate();
        t_timeout();
        t_sleep();
        t_tied();
        chk(v_mid == 0, "R5 start stable in bit window", v_mid, 0);
        chk(min_sw >= START_LOW, "R5 start low width", min_sw, START_LOW);
        chk(v_sleep == 0, "R10 no start while down", v_sleep, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule